// File: doc/BRIEF.md
# Variable Page-Size Translation Lookaside Buffer

This block is a fully associative translation buffer. Each entry carries its own page-size code, so 8 KB, 64 KB, 512 KB and 4 MB mappings can sit side by side. Virtual addresses are 64 bits wide, physical addresses are 41 bits wide, and contexts are 13 bits wide. A write port loads one entry at a time at an index chosen by the caller. The block has no replacement policy and no table walker.

A lookup presents a virtual address, a context choice, an access kind and a user flag. The context choice is primary, secondary or nucleus. The access kind is load, store, non-faulting load or instruction fetch. The result appears one cycle later:
- On a hit, the result is a translation and a rights mask.
- On a miss, it is a miss code.
- Otherwise it is a fault code or a write-protection code.

The same clock edge updates a status word, a fault-address register and a tag-access register, each as the outcome requires. A lookup in physical mode bypasses the entries altogether.

Top module: `vps_tlb`

## Requirements
- R1: An entry's size code s (0..3) excludes the low 13+3*s virtual address bits from the tag compare. The page sizes are therefore 8 KB, 64 KB, 512 KB and 4 MB.
- R2: An entry hits when all of the following hold:
  - it is valid;
  - its masked tag equals the masked address;
  - it is global, or its context equals the selected context.
  Select code 0 picks `pri_ctx`, 1 picks `sec_ctx`, and 2 or 3 pick context 0. The response code is 0 for a good hit and 1 for a miss.
- R3: The translated address takes its bits inside the page from the virtual address and the bits above from the entry. Bits 12:0 are zero.
- R4: A data lookup sets fault-type bits in the status word, and any of them yields response code 2. More than one bit may be set.
  - Bit 7 is set when a user access reaches a privileged page.
  - Bit 8 is set when a non-faulting load (kind 2) reaches a side-effect page.
  - Bit 9 is set when any other data kind reaches a non-fault-only page.
- R5: A store (kind 1) to a non-writable page with no R4 fault yields code 3, with fault-type bits 9:7 cleared.
- R6: On code 2 or 3, the status word is loaded as follows, and the fault-address register takes the virtual address.
  - bit 0: valid, set to 1.
  - bit 1: overflow, set to the previous valid bit.
  - bit 2: set for a store.
  - bit 3: set for a non-faulting load.
  - bit 4: privileged, meaning not user.
  - bits 6:5: context type (0 primary, 1 secondary, 2 nucleus, 3 none).
- R7: On a miss or a fault, the tag-access register is loaded with the virtual address with bits 12:0 cleared, ORed with the context used. A miss leaves the status word and the fault-address register unchanged.
- R8: A fetch (kind 3) uses `pri_ctx` with context type 0 when `lk_tl_zero` is high. Otherwise it uses context 0 with context type 2. A fetch checks only the privilege fault, and on a hit returns rights 3'b100.
- R9: A good hit sets the winning entry's used bit. Writing an entry clears its used bit.
- R10: A physical-mode lookup returns code 0, the low 41 address bits, and rights 3'b111. It changes no register.
- R11: When several entries hit, the lowest index wins.
- R12: `stat_ack` clears the status word. A fault recorded in the same cycle sees the valid bit as already cleared.
- R13: Data hit rights are bit 0 read (always set) and bit 1 write (set only when the page is writable). A lookup that does not hit reports rights 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry index to load |
| wr_va | input | 64 | Virtual tag address |
| wr_ctx | input | 13 | Entry context |
| wr_size | input | 2 | Page-size code |
| wr_pa | input | 41 | Physical page address |
| wr_valid | input | 1 | Entry valid |
| wr_global | input | 1 | Ignore context on match |
| wr_priv | input | 1 | Privileged-only page |
| wr_writable | input | 1 | Write allowed |
| wr_side_eff | input | 1 | Page has side effects |
| wr_nf_only | input | 1 | Non-fault-only page |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx_sel | input | 2 | Context choice for data |
| lk_kind | input | 2 | 0 load, 1 store, 2 non-faulting load, 3 fetch |
| lk_user | input | 1 | User-mode access |
| lk_tl_zero | input | 1 | Trap level is zero |
| lk_phys | input | 1 | Physical-mode bypass |
| stat_ack | input | 1 | Clear status word |
| rsp_vld | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 ok, 1 miss, 2 fault, 3 protection |
| rsp_pa | output | 41 | Translated address |
| rsp_perm | output | 3 | Rights: read, write, exec |
| stat_word | output | 10 | Fault status word |
| fault_addr | output | 64 | Last faulting address |
| tag_access | output | 64 | Last miss/fault tag word |
| used_vec | output | 64 | Per-entry used bits |

## Verification
A lookup presented before a rising edge is resolved within that cycle. Its response, status word, fault address, tag-access word and used bits are all registered at that same edge, so every result is due exactly one cycle after the request. An entry write takes effect at its edge, and the first lookup that can see it is the one presented in the following cycle.

The bench drives on the falling edge and compares every output at the next falling edge against a bench model. It updates the model's register state only after that comparison. Back-to-back faults, acknowledges, overlapping entries and physical-mode lookups are therefore all checked at the cycle their result lands.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;

   typedef enum logic [1:0] {
      RSP_OK    = 2'd0,
      RSP_MISS  = 2'd1,
      RSP_FAULT = 2'd2,
      RSP_PROT  = 2'd3
   } rsp_code_e;

   typedef enum logic [1:0] {
      ACC_LOAD   = 2'd0,
      ACC_STORE  = 2'd1,
      ACC_NFLOAD = 2'd2,
      ACC_FETCH  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      CT_PRIMARY   = 2'd0,
      CT_SECONDARY = 2'd1,
      CT_NUCLEUS   = 2'd2,
      CT_NONE      = 2'd3
   } ctx_type_e;

   localparam int STAT_W      = 10;
   localparam int ST_VALID    = 0;
   localparam int ST_OVF      = 1;
   localparam int ST_WRITE    = 2;
   localparam int ST_NF       = 3;
   localparam int ST_PRIV     = 4;
   localparam int ST_CT_LO    = 5;
   localparam int ST_FT_LO    = 7;
   localparam int FT_W        = 3;

endpackage

// File: rtl/vps_tlb_cam.sv
module vps_tlb_cam #(
   parameter int ENTRIES   = 64,
   parameter int VPN_W     = 51,
   parameter int PPN_W     = 28,
   parameter int CTX_W     = 13,
   parameter int SZ_W      = 2,
   parameter int SIZE_STEP = 3,
   parameter int IDX_W     = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [VPN_W-1:0]               wr_vpn,
   input  logic [CTX_W-1:0]               wr_ctx,
   input  logic [SZ_W-1:0]                wr_size,
   input  logic [PPN_W-1:0]               wr_ppn,
   input  logic                           wr_valid,
   input  logic                           wr_global,
   input  logic                           wr_priv,
   input  logic                           wr_writable,
   input  logic                           wr_side_eff,
   input  logic                           wr_nf_only,
   input  logic [VPN_W-1:0]               lk_vpn,
   input  logic [CTX_W-1:0]               lk_ctx,
   input  logic                           mark_en,
   input  logic [IDX_W-1:0]               mark_idx,
   output logic [ENTRIES-1:0]             hit_vec,
   output logic [ENTRIES-1:0][PPN_W-1:0]  ppn_merged,
   output logic [ENTRIES-1:0]             priv_vec,
   output logic [ENTRIES-1:0]             wok_vec,
   output logic [ENTRIES-1:0]             side_vec,
   output logic [ENTRIES-1:0]             nfo_vec,
   output logic [ENTRIES-1:0]             used_vec
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic              v_q, u_q, g_q, p_q, w_q, s_q, n_q;
      logic [SZ_W-1:0]   sz_q;
      logic [VPN_W-1:0]  vpn_q;
      logic [CTX_W-1:0]  ctx_q;
      logic [PPN_W-1:0]  ppn_q;
      logic [VPN_W-1:0]  keep;
      logic              sel_wr;

      assign sel_wr = wr_en && (wr_idx == IDX_W'(i));

      // State bits that must be known after reset
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            u_q <= 1'b0;
         end else if (sel_wr) begin
            v_q <= wr_valid;
            u_q <= 1'b0;
         end else if (mark_en && (mark_idx == IDX_W'(i))) begin
            u_q <= 1'b1;
         end
      end

      // Payload, qualified by v_q
      always_ff @(posedge clk) begin
         if (sel_wr) begin
            g_q   <= wr_global;
            p_q   <= wr_priv;
            w_q   <= wr_writable;
            s_q   <= wr_side_eff;
            n_q   <= wr_nf_only;
            sz_q  <= wr_size;
            vpn_q <= wr_vpn;
            ctx_q <= wr_ctx;
            ppn_q <= wr_ppn;
         end
      end

      // Page-number bits that take part in the compare
      always_comb keep = {VPN_W{1'b1}} << (SIZE_STEP * int'(sz_q));

      assign hit_vec[i] = v_q && (((vpn_q ^ lk_vpn) & keep) == '0)
                          && (g_q || (ctx_q == lk_ctx));
      assign ppn_merged[i] = (ppn_q & keep[PPN_W-1:0])
                           | (lk_vpn[PPN_W-1:0] & ~keep[PPN_W-1:0]);
      assign priv_vec[i] = p_q;
      assign wok_vec[i]  = w_q;
      assign side_vec[i] = s_q;
      assign nfo_vec[i]  = n_q;
      assign used_vec[i] = u_q;
   end

endmodule

// File: rtl/vps_tlb_prio.sv
module vps_tlb_prio #(
   parameter int N     = 64,
   parameter int IDX_W = 6
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   // Lowest requesting index wins
   always_comb begin
      any = |req;
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) idx = IDX_W'(k);
      end
   end

endmodule

// File: rtl/vps_tlb_fault.sv
module vps_tlb_fault
   import vps_tlb_pkg::*;
(
   input  logic              hit,
   input  logic [1:0]        kind,
   input  logic              user,
   input  logic [1:0]        ctx_type,
   input  logic              prev_valid,
   input  logic              pg_priv,
   input  logic              pg_wok,
   input  logic              pg_side,
   input  logic              pg_nfo,
   output logic [1:0]        code,
   output logic [2:0]        perm,
   output logic [STAT_W-1:0] st_new
);

   logic          f_priv, f_side, f_nfo, f_prot;
   logic [FT_W-1:0] ft;

   always_comb begin
      f_priv = pg_priv && user;
      f_side = 1'b0;
      f_nfo  = 1'b0;
      if (kind == ACC_NFLOAD)     f_side = pg_side;
      else if (kind != ACC_FETCH) f_nfo  = pg_nfo;
      ft     = {f_nfo, f_side, f_priv};
      f_prot = (kind == ACC_STORE) && !pg_wok && (ft == '0);

      if (!hit)             code = RSP_MISS;
      else if (ft != '0)    code = RSP_FAULT;
      else if (f_prot)      code = RSP_PROT;
      else                  code = RSP_OK;

      if (kind == ACC_FETCH) perm = 3'b100;
      else                   perm = {1'b0, pg_wok, 1'b1};

      st_new                          = '0;
      st_new[ST_VALID]                = 1'b1;
      st_new[ST_OVF]                  = prev_valid;
      st_new[ST_WRITE]                = (kind == ACC_STORE);
      st_new[ST_NF]                   = (kind == ACC_NFLOAD);
      st_new[ST_PRIV]                 = !user;
      st_new[ST_CT_LO +: 2]           = ctx_type;
      st_new[ST_FT_LO +: FT_W]        = ft;
   end

endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
   import vps_tlb_pkg::*;
#(
   parameter int ENTRIES   = 64,
   parameter int VA_W      = 64,
   parameter int PA_W      = 41,
   parameter int CTX_W     = 13,
   parameter int PAGE_BITS = 13,
   parameter int SIZE_STEP = 3,
   parameter int NUM_SIZES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(ENTRIES)-1:0]    wr_idx,
   input  logic [VA_W-1:0]               wr_va,
   input  logic [CTX_W-1:0]              wr_ctx,
   input  logic [$clog2(NUM_SIZES)-1:0]  wr_size,
   input  logic [PA_W-1:0]               wr_pa,
   input  logic                          wr_valid,
   input  logic                          wr_global,
   input  logic                          wr_priv,
   input  logic                          wr_writable,
   input  logic                          wr_side_eff,
   input  logic                          wr_nf_only,
   input  logic [CTX_W-1:0]              pri_ctx,
   input  logic [CTX_W-1:0]              sec_ctx,
   input  logic                          lk_valid,
   input  logic [VA_W-1:0]               lk_va,
   input  logic [1:0]                    lk_ctx_sel,
   input  logic [1:0]                    lk_kind,
   input  logic                          lk_user,
   input  logic                          lk_tl_zero,
   input  logic                          lk_phys,
   input  logic                          stat_ack,
   output logic                          rsp_vld,
   output logic [1:0]                    rsp_code,
   output logic [PA_W-1:0]               rsp_pa,
   output logic [2:0]                    rsp_perm,
   output logic [STAT_W-1:0]             stat_word,
   output logic [VA_W-1:0]               fault_addr,
   output logic [VA_W-1:0]               tag_access,
   output logic [ENTRIES-1:0]            used_vec
);

   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PPN_W = PA_W - PAGE_BITS;
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int SZ_W  = $clog2(NUM_SIZES);

   if (ENTRIES < 2) begin : g_chk_entries
      $error("vps_tlb: ENTRIES must be at least 2");
   end
   if (CTX_W > PAGE_BITS) begin : g_chk_ctx
      $error("vps_tlb: context must fit below the page offset");
   end
   if (SIZE_STEP * (NUM_SIZES - 1) >= PPN_W) begin : g_chk_size
      $error("vps_tlb: largest page exceeds physical space");
   end
   if (PA_W > VA_W) begin : g_chk_pa
      $error("vps_tlb: physical width exceeds virtual width");
   end

   logic [CTX_W-1:0] sel_ctx;
   logic [1:0]       ctx_type;

   always_comb begin
      if (lk_kind == ACC_FETCH) begin
         sel_ctx  = lk_tl_zero ? pri_ctx : '0;
         ctx_type = lk_tl_zero ? CT_PRIMARY : CT_NUCLEUS;
      end else begin
         case (lk_ctx_sel)
            2'd0:    sel_ctx = pri_ctx;
            2'd1:    sel_ctx = sec_ctx;
            default: sel_ctx = '0;
         endcase
         ctx_type = lk_ctx_sel;
      end
   end

   logic [ENTRIES-1:0]            hit_vec, priv_vec, wok_vec, side_vec, nfo_vec;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_merged;
   logic                          any_hit, mark_en;
   logic [IDX_W-1:0]              win_idx;
   logic [1:0]                    code_c;
   logic [2:0]                    perm_c;
   logic [STAT_W-1:0]             st_new;
   logic                          prev_valid;
   logic                          unused_low;

   assign unused_low = ^{wr_va[PAGE_BITS-1:0], wr_pa[PAGE_BITS-1:0]};

   vps_tlb_cam #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W),
      .SZ_W(SZ_W), .SIZE_STEP(SIZE_STEP), .IDX_W(IDX_W)
   ) u_cam (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_va[VA_W-1:PAGE_BITS]),
      .wr_ctx(wr_ctx), .wr_size(wr_size), .wr_ppn(wr_pa[PA_W-1:PAGE_BITS]),
      .wr_valid(wr_valid), .wr_global(wr_global), .wr_priv(wr_priv),
      .wr_writable(wr_writable), .wr_side_eff(wr_side_eff), .wr_nf_only(wr_nf_only),
      .lk_vpn(lk_va[VA_W-1:PAGE_BITS]), .lk_ctx(sel_ctx),
      .mark_en(mark_en), .mark_idx(win_idx),
      .hit_vec(hit_vec), .ppn_merged(ppn_merged), .priv_vec(priv_vec),
      .wok_vec(wok_vec), .side_vec(side_vec), .nfo_vec(nfo_vec),
      .used_vec(used_vec)
   );

   vps_tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
      .req(hit_vec), .any(any_hit), .idx(win_idx)
   );

   assign prev_valid = stat_word[ST_VALID] && !stat_ack;

   vps_tlb_fault u_fault (
      .hit(any_hit), .kind(lk_kind), .user(lk_user), .ctx_type(ctx_type),
      .prev_valid(prev_valid),
      .pg_priv(priv_vec[win_idx]), .pg_wok(wok_vec[win_idx]),
      .pg_side(side_vec[win_idx]), .pg_nfo(nfo_vec[win_idx]),
      .code(code_c), .perm(perm_c), .st_new(st_new)
   );

   assign mark_en = lk_valid && !lk_phys && (code_c == RSP_OK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld    <= 1'b0;
         rsp_code   <= RSP_OK;
         rsp_pa     <= '0;
         rsp_perm   <= '0;
         stat_word  <= '0;
         fault_addr <= '0;
         tag_access <= '0;
      end else begin
         rsp_vld <= lk_valid;
         if (stat_ack) stat_word <= '0;
         if (lk_valid) begin
            if (lk_phys) begin
               rsp_code <= RSP_OK;
               rsp_pa   <= lk_va[PA_W-1:0];
               rsp_perm <= 3'b111;
            end else begin
               rsp_code <= code_c;
               rsp_pa   <= (code_c == RSP_OK) ?
                           {ppn_merged[win_idx], {PAGE_BITS{1'b0}}} : '0;
               rsp_perm <= (code_c == RSP_OK) ? perm_c : 3'b000;
               if (code_c != RSP_OK) begin
                  tag_access <= {lk_va[VA_W-1:PAGE_BITS], PAGE_BITS'(sel_ctx)};
               end
               if ((code_c == RSP_FAULT) || (code_c == RSP_PROT)) begin
                  stat_word  <= st_new;
                  fault_addr <= lk_va;
               end
            end
         end
      end
   end

endmodule

// File: rtl/vps_tlb_chk.sv
module vps_tlb_chk #(
   parameter int VA_W = 64,
   parameter int PA_W = 41
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic            lk_phys,
   input logic [VA_W-1:0] lk_va,
   input logic            stat_ack,
   input logic            rsp_vld,
   input logic [1:0]      rsp_code,
   input logic [PA_W-1:0] rsp_pa,
   input logic [2:0]      rsp_perm,
   input logic [9:0]      stat_word,
   input logic [VA_W-1:0] fault_addr
);

   p_resp_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_vld);

   p_fault_has_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code == 2'd2) |-> (stat_word[9:7] != 3'b000));

   p_prot_no_type_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code == 2'd3) |-> (stat_word[9:7] == 3'b000 && stat_word[2]));

   p_fault_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_phys) |=> (rsp_code[1] |-> (stat_word[0] && fault_addr == $past(lk_va))));

   p_miss_keeps_fa_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code == 2'd1) |-> $stable(fault_addr));

   p_miss_keeps_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code == 2'd1 && !$past(stat_ack)) |-> $stable(stat_word));

   p_phys_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_phys) |=>
         (rsp_code == 2'd0 && rsp_perm == 3'b111 && rsp_pa == $past(lk_va[PA_W-1:0])));

   p_ok_has_rights_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code == 2'd0) |-> (rsp_perm != 3'b000));

   p_bad_no_rights_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code != 2'd0) |-> (rsp_perm == 3'b000 && rsp_pa == '0));

endmodule

bind vps_tlb vps_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_phys(lk_phys),
   .lk_va(lk_va), .stat_ack(stat_ack), .rsp_vld(rsp_vld),
   .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm),
   .stat_word(stat_word), .fault_addr(fault_addr)
);

// File: tb/tb_vps_tlb.sv
`timescale 1ns/1ps
module tb_vps_tlb;

   localparam logic [12:0] PCTX = 13'h005;
   localparam logic [12:0] SCTX = 13'h009;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 0, wr_valid = 0, wr_global = 0, wr_priv = 0;
   logic        wr_writable = 0, wr_side_eff = 0, wr_nf_only = 0;
   logic [5:0]  wr_idx = '0;
   logic [63:0] wr_va = '0;
   logic [12:0] wr_ctx = '0;
   logic [1:0]  wr_size = '0;
   logic [40:0] wr_pa = '0;
   logic        lk_valid = 0, lk_user = 0, lk_tl_zero = 1, lk_phys = 0, stat_ack = 0;
   logic [63:0] lk_va = '0;
   logic [1:0]  lk_ctx_sel = '0, lk_kind = '0;
   logic        rsp_vld;
   logic [1:0]  rsp_code;
   logic [40:0] rsp_pa;
   logic [2:0]  rsp_perm;
   logic [9:0]  stat_word;
   logic [63:0] fault_addr, tag_access;
   logic [63:0] used_vec;

   always #2.5 clk = ~clk;

   vps_tlb dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_va(wr_va),
      .wr_ctx(wr_ctx), .wr_size(wr_size), .wr_pa(wr_pa), .wr_valid(wr_valid),
      .wr_global(wr_global), .wr_priv(wr_priv), .wr_writable(wr_writable),
      .wr_side_eff(wr_side_eff), .wr_nf_only(wr_nf_only),
      .pri_ctx(PCTX), .sec_ctx(SCTX), .lk_valid(lk_valid), .lk_va(lk_va),
      .lk_ctx_sel(lk_ctx_sel), .lk_kind(lk_kind), .lk_user(lk_user),
      .lk_tl_zero(lk_tl_zero), .lk_phys(lk_phys), .stat_ack(stat_ack),
      .rsp_vld(rsp_vld), .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm),
      .stat_word(stat_word), .fault_addr(fault_addr), .tag_access(tag_access),
      .used_vec(used_vec)
   );

   // Bench model of the entries and registers
   bit          m_v[64], m_g[64], m_p[64], m_w[64], m_s[64], m_n[64];
   logic [1:0]  m_sz[64];
   logic [50:0] m_vpn[64];
   logic [12:0] m_ctx[64];
   logic [27:0] m_ppn[64];
   logic [63:0] m_used;
   logic [9:0]  m_stat;
   logic [63:0] m_fa, m_ta;

   int n_chk = 0, n_bad = 0;

   task automatic chk(string tg, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tg, act, exp);
      end
   endtask

   task automatic wr_entry(int idx, logic [50:0] vpn, logic [12:0] ctx, logic [1:0] sz,
                           logic [27:0] ppn, bit v, bit g, bit p, bit w, bit s, bit n);
      @(negedge clk);
      wr_en = 1; wr_idx = 6'(idx); wr_va = {vpn, 13'h1abc}; wr_ctx = ctx;
      wr_size = sz; wr_pa = {ppn, 13'h0f0f}; wr_valid = v; wr_global = g;
      wr_priv = p; wr_writable = w; wr_side_eff = s; wr_nf_only = n;
      @(negedge clk);
      wr_en = 0;
      m_v[idx] = v; m_g[idx] = g; m_p[idx] = p; m_w[idx] = w; m_s[idx] = s;
      m_n[idx] = n; m_sz[idx] = sz; m_vpn[idx] = vpn; m_ctx[idx] = ctx;
      m_ppn[idx] = ppn; m_used[idx] = 1'b0;
   endtask

   function automatic bit m_match(int k, logic [50:0] vpn, logic [12:0] ctx);
      logic [50:0] keep;
      keep = ~51'h0 << (3 * int'(m_sz[k]));
      return m_v[k] && (((m_vpn[k] ^ vpn) & keep) == '0) && (m_g[k] || m_ctx[k] == ctx);
   endfunction

   task automatic lookup(string tg, logic [63:0] va, logic [1:0] sel, logic [1:0] kind,
                         bit user, bit tl0, bit phys, bit ack);
      logic [12:0] ctx;
      logic [1:0]  ctype, e_code;
      logic [2:0]  e_perm, ft;
      logic [40:0] e_pa;
      logic [27:0] keep;
      bit          found, prevv;
      int          idx;
      if (kind == 2'd3) begin
         ctx = tl0 ? PCTX : 13'h0; ctype = tl0 ? 2'd0 : 2'd2;
      end else begin
         ctx = (sel == 2'd0) ? PCTX : (sel == 2'd1) ? SCTX : 13'h0; ctype = sel;
      end
      found = 0; idx = 0;
      for (int k = 0; k < 64; k++) begin
         if (!found && m_match(k, va[63:13], ctx)) begin found = 1; idx = k; end
      end
      ft = 3'b000; e_pa = '0; e_perm = 3'b000;
      if (phys) begin
         e_code = 2'd0; e_pa = va[40:0]; e_perm = 3'b111;
      end else if (!found) begin
         e_code = 2'd1;
      end else begin
         ft[0] = m_p[idx] && user;
         if (kind == 2'd2)      ft[1] = m_s[idx];
         else if (kind != 2'd3) ft[2] = m_n[idx];
         if (ft != 0)                                 e_code = 2'd2;
         else if (kind == 2'd1 && !m_w[idx])          e_code = 2'd3;
         else                                         e_code = 2'd0;
         if (e_code == 2'd0) begin
            keep   = ~28'h0 << (3 * int'(m_sz[idx]));
            e_pa   = {(m_ppn[idx] & keep) | (va[40:13] & ~keep), 13'h0};
            e_perm = (kind == 2'd3) ? 3'b100 : {1'b0, m_w[idx], 1'b1};
         end
      end
      // drive
      lk_valid = 1; lk_va = va; lk_ctx_sel = sel; lk_kind = kind; lk_user = user;
      lk_tl_zero = tl0; lk_phys = phys; stat_ack = ack;
      // model register update
      prevv = m_stat[0] && !ack;
      if (ack) m_stat = '0;
      if (!phys && e_code != 2'd0) m_ta = {va[63:13], ctx};
      if (!phys && e_code[1]) begin
         m_stat = {ft, ctype, !user, kind == 2'd2, kind == 2'd1, prevv, 1'b1};
         m_fa = va;
      end
      if (!phys && e_code == 2'd0) m_used[idx] = 1'b1;
      @(negedge clk);
      lk_valid = 0; stat_ack = 0;
      chk({tg, " R2 rsp_vld"}, 64'(rsp_vld), 64'd1);
      chk({tg, " R2/R4/R5 code"}, 64'(rsp_code), 64'(e_code));
      chk({tg, " R3 pa"}, 64'(rsp_pa), 64'(e_pa));
      chk({tg, " R13 perm"}, 64'(rsp_perm), 64'(e_perm));
      chk({tg, " R6 status"}, 64'(stat_word), 64'(m_stat));
      chk({tg, " R6 fault_addr"}, fault_addr, m_fa);
      chk({tg, " R7 tag_access"}, tag_access, m_ta);
      chk({tg, " R9 used"}, used_vec, m_used);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [50:0] vpn;
      logic [12:0] ctxs[4];
      ctxs[0] = PCTX; ctxs[1] = SCTX; ctxs[2] = 13'h0; ctxs[3] = 13'h7;
      void'($urandom(32'h5eed_1234));
      for (int k = 0; k < 64; k++) begin
         m_v[k] = 0; m_sz[k] = 0; m_vpn[k] = 0; m_ctx[k] = 0; m_ppn[k] = 0;
         m_g[k] = 0; m_p[k] = 0; m_w[k] = 0; m_s[k] = 0; m_n[k] = 0;
      end
      m_used = '0; m_stat = '0; m_fa = '0; m_ta = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk("reset rsp_vld", 64'(rsp_vld), 64'd0);
      chk("reset R6 status", 64'(stat_word), 64'd0);
      chk("reset R7 tag_access", tag_access, 64'd0);
      chk("reset R9 used", used_vec, 64'd0);

      // R1: 4 MB page at entry 30 and 8 KB page at entry 31
      vpn = 51'h1234_5678_9000;
      wr_entry(30, vpn, PCTX, 2'd3, 28'hA55_5000, 1, 0, 0, 1, 0, 0);
      lookup("R1 4M inside", {vpn, 13'h0} ^ 64'h20_0000, 2'd0, 2'd0, 0, 1, 0, 0);
      lookup("R1 4M outside", {vpn, 13'h0} ^ 64'h40_0000, 2'd0, 2'd0, 0, 1, 0, 0);
      wr_entry(31, 51'h0abc_def0_0001, SCTX, 2'd0, 28'h123_4567, 1, 0, 0, 0, 0, 0);
      lookup("R1 8K exact", {51'h0abc_def0_0001, 13'h1ff8}, 2'd1, 2'd0, 1, 1, 0, 0);
      lookup("R1 8K neighbour", {51'h0abc_def0_0000, 13'h0}, 2'd1, 2'd0, 1, 1, 0, 0);
      // R2: wrong context misses
      lookup("R2 ctx mismatch", {51'h0abc_def0_0001, 13'h0}, 2'd0, 2'd0, 1, 1, 0, 0);
      // R5: store to read-only page
      lookup("R5 store ro", {51'h0abc_def0_0001, 13'h4}, 2'd1, 2'd1, 1, 1, 0, 0);
      // R11: two overlapping global entries
      wr_entry(40, 51'h7_7777_0000, 13'h1, 2'd1, 28'h0ee_e000, 1, 1, 0, 1, 0, 0);
      wr_entry(41, 51'h7_7777_0000, 13'h2, 2'd1, 28'h0dd_d000, 1, 1, 0, 1, 0, 0);
      lookup("R11 lowest wins", {51'h7_7777_0003, 13'h10}, 2'd2, 2'd1, 0, 1, 0, 0);
      // R4: privileged + nf-only page, user load: two fault bits at once
      wr_entry(42, 51'h3_3333_3333, PCTX, 2'd0, 28'h111_1111, 1, 0, 1, 1, 1, 1);
      lookup("R4 multi fault", {51'h3_3333_3333, 13'h0}, 2'd0, 2'd0, 1, 1, 0, 0);
      lookup("R4 nf side", {51'h3_3333_3333, 13'h0}, 2'd0, 2'd2, 0, 1, 0, 0);
      // R12: overflow then acknowledge
      lookup("R12 ack with fault", {51'h3_3333_3333, 13'h0}, 2'd0, 2'd0, 1, 1, 0, 1);
      lookup("R12 ack alone", 64'h0, 2'd0, 2'd0, 0, 1, 1, 1);
      // R8: fetch at trap level >0 uses context 0
      wr_entry(43, 51'h5_0000_0001, 13'h0, 2'd0, 28'h222_2222, 1, 0, 1, 0, 1, 1);
      lookup("R8 fetch nucleus", {51'h5_0000_0001, 13'h0}, 2'd0, 2'd3, 0, 0, 0, 0);
      lookup("R8 fetch primary miss", {51'h5_0000_0001, 13'h0}, 2'd0, 2'd3, 0, 1, 0, 0);
      lookup("R8 fetch user priv", {51'h5_0000_0001, 13'h0}, 2'd0, 2'd3, 1, 0, 0, 0);
      // R10: physical mode
      lookup("R10 phys", 64'hffff_ffff_ffff_fff8, 2'd0, 2'd1, 1, 1, 1, 0);
      // R9: rewrite clears used bit
      wr_entry(43, 51'h5_0000_0001, 13'h0, 2'd0, 28'h222_2222, 1, 0, 1, 0, 1, 1);
      chk("R9 used cleared by write", used_vec, m_used);

      // random entries and lookups
      for (int k = 0; k < 24; k++) begin
         wr_entry(k, 51'({$urandom(), $urandom()}), ctxs[$urandom % 4], 2'($urandom % 4),
                  28'($urandom), ($urandom % 8) != 0, ($urandom % 4) == 0,
                  ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
                  ($urandom % 6) == 0);
      end
      for (int t = 0; t < 400; t++) begin
         int          k;
         logic [50:0] off;
         logic [63:0] va;
         k = $urandom % 28;
         if (k < 24) begin
            off = 51'($urandom) & ~(~51'h0 << (3 * int'(m_sz[k])));
            va  = {m_vpn[k] ^ off, 13'($urandom)};
         end else begin
            va = {$urandom(), $urandom()};
         end
         lookup("rand", va, 2'($urandom % 4), 2'($urandom % 4), $urandom % 2,
                ($urandom % 3) != 0, ($urandom % 16) == 0, ($urandom % 8) == 0);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule